// File: doc/BRIEF.md
# Translation Buffer with Access-Rights Checking

A fully associative cache of page translations. Each lookup gives a 32-bit virtual address, an access kind (read, write or instruction fetch) and a user/supervisor flag. One cycle later the block reports a hit or a miss. On a hit it also returns the physical address, the cacheability attribute and a fault code from the rights check. A miss only tells the surrounding logic to fetch the page descriptor and push it in through the refill port. This block does no table walk itself.

Software controls the block through a small command port. Writing the context pointer starts a new address space: every non-global entry is dropped and global entries are kept. A mode write turns translation on or off. A line invalidate removes the one entry that matches a given address. A read command returns either the faulting-address register or the fault-code register. Pages are 4 KB, the physical address is 36 bits wide, and the default buffer holds 8 entries.

Top module: `tlb_xlate`

## Requirements
- R1: A refill descriptor is decoded as: bits 31:30 entry kind, bit 29 cacheable, bit 28 writable, bit 27 executable, bit 26 user-accessible, bit 25 global, bit 24 dirty, bits 23:0 physical page number. An entry is valid only if its kind field is nonzero.
- R2: With translation on, a lookup whose page number (address bits 31:12) matches a valid entry reports hit one cycle later, with physical address = {page number, address bits 11:0}.
- R3: On a hit, the cacheable output equals the entry's cacheable bit.
- R4: A lookup with no matching valid entry reports miss (hit low, fault low, code 0) and leaves the fault registers unchanged.
- R5: A user-mode access (user flag 1) to an entry whose user bit is clear faults with code 1. This check has the highest priority.
- R6: Otherwise, a write (access kind 1) to an entry whose writable bit is clear faults with code 2.
- R7: Otherwise, a fetch (access kind 2) from an entry whose executable bit is clear faults with code 3. Kinds 0 and 3 are reads.
- R8: Otherwise, a write to an entry whose dirty bit is clear faults with code 4.
- R9: A fault loads the virtual address into the bad-address register and the code into the fault-code register. A read command (command 3) returns the bad address when data bit 0 is 0 and the code when it is 1, one cycle later.
- R10: A context-pointer write (command 0) stores the data on the context output and invalidates every entry whose global bit is clear. Global entries keep translating.
- R11: A line invalidate (command 2) removes only the valid entry whose page number matches data bits 31:12.
- R12: A mode write (command 1) sets translation on from data bit 0. Translation is off after reset. While off, each lookup reports hit with no fault, cacheable 1, and physical address equal to the zero-extended virtual address.
- R13: Refills fill slots in round-robin order starting at slot 0, so the ninth refill overwrites the first slot written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Lookup virtual address |
| lk_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| lk_user_i | input | 1 | Request is from user mode |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | No translation; refill needed |
| lk_fault_o | output | 1 | Rights check failed |
| lk_err_o | output | 3 | Fault code |
| lk_paddr_o | output | 36 | Physical address |
| lk_cacheable_o | output | 1 | Cacheability attribute |
| rf_valid_i | input | 1 | Refill write |
| rf_vaddr_i | input | 32 | Virtual address of refilled page |
| rf_desc_i | input | 32 | Page descriptor |
| ctl_valid_i | input | 1 | Command strobe |
| ctl_cmd_i | input | 2 | Command: 0 context, 1 mode, 2 invalidate, 3 read |
| ctl_wdata_i | input | 32 | Command data |
| ctl_rdata_o | output | 32 | Read data |
| ctx_ptr_o | output | 32 | Current context pointer |

## Verification
Lookup results, fault-register updates and read data are all registered, so each one is due at the first rising edge after its request. A refill, flush, invalidate or mode change is visible to a lookup made in the following cycle. The bench drives every request on a falling edge and samples the result on the next falling edge, exactly one edge later. It waits one more cycle before issuing a lookup that depends on a state change.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = 24;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int DESC_W = 32;
  localparam int ERR_W  = 3;

  localparam int D_KIND_HI = 31;
  localparam int D_KIND_LO = 30;
  localparam int D_C = 29;
  localparam int D_W = 28;
  localparam int D_X = 27;
  localparam int D_U = 26;
  localparam int D_G = 25;
  localparam int D_D = 24;

  typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_FETCH, ACC_RSVD} acc_e;
  typedef enum logic [1:0] {CMD_CTX, CMD_MODE, CMD_INVAL, CMD_READ} cmd_e;
  typedef enum logic [ERR_W-1:0] {
    ERR_NONE   = 3'd0,
    ERR_USER   = 3'd1,
    ERR_WPROT  = 3'd2,
    ERR_NOEXEC = 3'd3,
    ERR_DIRTY  = 3'd4
  } err_e;

  typedef struct packed {
    logic c;
    logic w;
    logic x;
    logic u;
    logic g;
    logic d;
  } attr_t;

  function automatic attr_t desc_attr(logic [DESC_W-1:0] desc);
    attr_t a;
    a.c = desc[D_C];
    a.w = desc[D_W];
    a.x = desc[D_X];
    a.u = desc[D_U];
    a.g = desc[D_G];
    a.d = desc[D_D];
    return a;
  endfunction

  function automatic logic desc_valid(logic [DESC_W-1:0] desc);
    return |desc[D_KIND_HI:D_KIND_LO];
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [DESC_W-1:0] wr_desc_i,
  input  logic              flush_i,
  input  logic              inval_i,
  input  logic [VPN_W-1:0]  inval_vpn_i,
  input  logic [VPN_W-1:0]  look_vpn_i,
  output logic              hit_o,
  output attr_t             attr_o,
  output logic [PPN_W-1:0]  ppn_o
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [N_ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]     vpn_q  [N_ENTRIES];
  logic [PPN_W-1:0]     ppn_q  [N_ENTRIES];
  attr_t                attr_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] look_match, inval_match;
  logic [IDX_W-1:0]     rr_q;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign look_match[g]  = valid_q[g] && (vpn_q[g] == look_vpn_i);
    assign inval_match[g] = valid_q[g] && (vpn_q[g] == inval_vpn_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        ppn_q[i]  <= '0;
        attr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (flush_i && !attr_q[i].g) valid_q[i] <= 1'b0;
        if (inval_i && inval_match[i]) valid_q[i] <= 1'b0;
        // refill wins over a same-cycle flush for its own slot
        if (wr_i && rr_q == IDX_W'(i)) begin
          valid_q[i] <= desc_valid(wr_desc_i);
          vpn_q[i]   <= wr_vpn_i;
          ppn_q[i]   <= wr_desc_i[PPN_W-1:0];
          attr_q[i]  <= desc_attr(wr_desc_i);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rr_q <= '0;
    else if (wr_i) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  // lowest index wins if a page was refilled twice
  always_comb begin
    hit_o  = |look_match;
    attr_o = '0;
    ppn_o  = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (look_match[i]) begin
        attr_o = attr_q[i];
        ppn_o  = ppn_q[i];
      end
    end
  end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  attr_t attr_i,
  input  acc_e  acc_i,
  input  logic  user_i,
  output err_e  err_o
);
  always_comb begin
    err_o = ERR_NONE;
    if (user_i && !attr_i.u)                   err_o = ERR_USER;
    else if (acc_i == ACC_WRITE && !attr_i.w)  err_o = ERR_WPROT;
    else if (acc_i == ACC_FETCH && !attr_i.x)  err_o = ERR_NOEXEC;
    else if (acc_i == ACC_WRITE && !attr_i.d)  err_o = ERR_DIRTY;
  end
endmodule

// File: rtl/tlb_ctrl_regs.sv
module tlb_ctrl_regs
  import tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_valid_i,
  input  cmd_e              ctl_cmd_i,
  input  logic [VA_W-1:0]   ctl_wdata_i,
  input  logic              fault_i,
  input  logic [VA_W-1:0]   fault_va_i,
  input  err_e              fault_err_i,
  output logic [VA_W-1:0]   ctx_ptr_o,
  output logic              en_o,
  output logic              flush_o,
  output logic              inval_o,
  output logic [VPN_W-1:0]  inval_vpn_o,
  output logic [VA_W-1:0]   rdata_o,
  output logic [VA_W-1:0]   bad_vaddr_o,
  output logic [ERR_W-1:0]  err_type_o
);
  assign flush_o     = ctl_valid_i && ctl_cmd_i == CMD_CTX;
  assign inval_o     = ctl_valid_i && ctl_cmd_i == CMD_INVAL;
  assign inval_vpn_o = ctl_wdata_i[VA_W-1:OFF_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_ptr_o <= '0;
      en_o      <= 1'b0;
      rdata_o   <= '0;
    end else if (ctl_valid_i) begin
      case (ctl_cmd_i)
        CMD_CTX:  ctx_ptr_o <= ctl_wdata_i;
        CMD_MODE: en_o      <= ctl_wdata_i[0];
        CMD_READ: rdata_o   <= ctl_wdata_i[0] ? VA_W'(err_type_o) : bad_vaddr_o;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_vaddr_o <= '0;
      err_type_o  <= '0;
    end else if (fault_i) begin
      bad_vaddr_o <= fault_va_i;
      err_type_o  <= fault_err_i;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lk_valid_i,
  input  logic [31:0] lk_vaddr_i,
  input  logic [1:0]  lk_acc_i,
  input  logic        lk_user_i,
  output logic        lk_done_o,
  output logic        lk_hit_o,
  output logic        lk_miss_o,
  output logic        lk_fault_o,
  output logic [2:0]  lk_err_o,
  output logic [35:0] lk_paddr_o,
  output logic        lk_cacheable_o,
  input  logic        rf_valid_i,
  input  logic [31:0] rf_vaddr_i,
  input  logic [31:0] rf_desc_i,
  input  logic        ctl_valid_i,
  input  logic [1:0]  ctl_cmd_i,
  input  logic [31:0] ctl_wdata_i,
  output logic [31:0] ctl_rdata_o,
  output logic [31:0] ctx_ptr_o
);
  logic             xlate_en, flush, inval, arr_hit, fault_evt;
  logic [VPN_W-1:0] inval_vpn;
  logic [PPN_W-1:0] arr_ppn;
  attr_t            arr_attr;
  err_e             chk_err;
  logic [VA_W-1:0]  bad_vaddr;
  logic [ERR_W-1:0] err_type;

  tlb_entry_array #(.N_ENTRIES(N_ENTRIES)) i_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (rf_valid_i),
    .wr_vpn_i    (rf_vaddr_i[VA_W-1:OFF_W]),
    .wr_desc_i   (rf_desc_i),
    .flush_i     (flush),
    .inval_i     (inval),
    .inval_vpn_i (inval_vpn),
    .look_vpn_i  (lk_vaddr_i[VA_W-1:OFF_W]),
    .hit_o       (arr_hit),
    .attr_o      (arr_attr),
    .ppn_o       (arr_ppn)
  );

  tlb_perm_check i_perm (
    .attr_i (arr_attr),
    .acc_i  (acc_e'(lk_acc_i)),
    .user_i (lk_user_i),
    .err_o  (chk_err)
  );

  assign fault_evt = lk_valid_i && xlate_en && arr_hit && (chk_err != ERR_NONE);

  tlb_ctrl_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_valid_i (ctl_valid_i),
    .ctl_cmd_i   (cmd_e'(ctl_cmd_i)),
    .ctl_wdata_i (ctl_wdata_i),
    .fault_i     (fault_evt),
    .fault_va_i  (lk_vaddr_i),
    .fault_err_i (chk_err),
    .ctx_ptr_o   (ctx_ptr_o),
    .en_o        (xlate_en),
    .flush_o     (flush),
    .inval_o     (inval),
    .inval_vpn_o (inval_vpn),
    .rdata_o     (ctl_rdata_o),
    .bad_vaddr_o (bad_vaddr),
    .err_type_o  (err_type)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o      <= 1'b0;
      lk_hit_o       <= 1'b0;
      lk_miss_o      <= 1'b0;
      lk_fault_o     <= 1'b0;
      lk_err_o       <= '0;
      lk_paddr_o     <= '0;
      lk_cacheable_o <= 1'b0;
    end else begin
      lk_done_o <= lk_valid_i;
      if (!lk_valid_i) begin
        lk_hit_o   <= 1'b0;
        lk_miss_o  <= 1'b0;
        lk_fault_o <= 1'b0;
        lk_err_o   <= '0;
      end else if (!xlate_en) begin
        lk_hit_o       <= 1'b1;
        lk_miss_o      <= 1'b0;
        lk_fault_o     <= 1'b0;
        lk_err_o       <= '0;
        lk_paddr_o     <= PA_W'(lk_vaddr_i);
        lk_cacheable_o <= 1'b1;
      end else begin
        lk_hit_o       <= arr_hit;
        lk_miss_o      <= !arr_hit;
        lk_fault_o     <= fault_evt;
        lk_err_o       <= arr_hit ? chk_err : ERR_NONE;
        lk_paddr_o     <= arr_hit ? {arr_ppn, lk_vaddr_i[OFF_W-1:0]} : '0;
        lk_cacheable_o <= arr_hit && arr_attr.c;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lk_valid_i,
  input logic [31:0] lk_vaddr_i,
  input logic        lk_done_o,
  input logic        lk_hit_o,
  input logic        lk_miss_o,
  input logic        lk_fault_o,
  input logic [2:0]  lk_err_o,
  input logic [35:0] lk_paddr_o,
  input logic        xlate_en,
  input logic [31:0] bad_vaddr,
  input logic [2:0]  err_type
);
  p_hit_miss_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_done_o |-> (lk_hit_o ^ lk_miss_o));

  p_fault_on_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> (lk_hit_o && lk_done_o));

  p_code_needs_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && !lk_fault_o) |-> (lk_err_o == 3'd0));

  p_fault_code_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> (lk_err_o >= 3'd1 && lk_err_o <= 3'd4));

  p_fault_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> (err_type == lk_err_o && bad_vaddr == $past(lk_vaddr_i)));

  p_fault_regs_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_fault_o |-> ($stable(err_type) && $stable(bad_vaddr)));

  p_bypass_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !xlate_en) |=>
      (lk_hit_o && !lk_fault_o && lk_paddr_o == {4'b0, $past(lk_vaddr_i)}));
endmodule

bind tlb_xlate tlb_xlate_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lk_valid_i (lk_valid_i),
  .lk_vaddr_i (lk_vaddr_i),
  .lk_done_o  (lk_done_o),
  .lk_hit_o   (lk_hit_o),
  .lk_miss_o  (lk_miss_o),
  .lk_fault_o (lk_fault_o),
  .lk_err_o   (lk_err_o),
  .lk_paddr_o (lk_paddr_o),
  .xlate_en   (xlate_en),
  .bad_vaddr  (bad_vaddr),
  .err_type   (err_type)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_user = 1'b0;
  logic        lk_done, lk_hit, lk_miss, lk_fault, lk_cacheable;
  logic [2:0]  lk_err;
  logic [35:0] lk_paddr;
  logic        rf_valid = 1'b0;
  logic [31:0] rf_vaddr = '0, rf_desc = '0;
  logic        ctl_valid = 1'b0;
  logic [1:0]  ctl_cmd = '0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata, ctx_ptr;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tlb_xlate i_tlb_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_acc_i(lk_acc), .lk_user_i(lk_user),
    .lk_done_o(lk_done), .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_fault_o(lk_fault),
    .lk_err_o(lk_err), .lk_paddr_o(lk_paddr), .lk_cacheable_o(lk_cacheable),
    .rf_valid_i(rf_valid), .rf_vaddr_i(rf_vaddr), .rf_desc_i(rf_desc),
    .ctl_valid_i(ctl_valid), .ctl_cmd_i(ctl_cmd), .ctl_wdata_i(ctl_wdata),
    .ctl_rdata_o(ctl_rdata), .ctx_ptr_o(ctx_ptr)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic        user;
    logic        hit;
    logic        fault;
    logic [2:0]  err;
    logic [35:0] pa;
    logic        c;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0123, 2'd0, 1'b1, 1'b1, 1'b0, 3'd0, 36'h000AB0123, 1'b1},
    '{32'h0001_0456, 2'd1, 1'b1, 1'b1, 1'b0, 3'd0, 36'h000AB0456, 1'b1},
    '{32'h0001_0000, 2'd2, 1'b1, 1'b1, 1'b1, 3'd3, 36'h0, 1'b0},
    '{32'h0002_0FFF, 2'd2, 1'b0, 1'b1, 1'b0, 3'd0, 36'h123456FFF, 1'b0},
    '{32'h0002_0010, 2'd0, 1'b1, 1'b1, 1'b1, 3'd1, 36'h0, 1'b0},
    '{32'h0002_0010, 2'd1, 1'b0, 1'b1, 1'b1, 3'd2, 36'h0, 1'b0},
    '{32'h0003_0ABC, 2'd1, 1'b1, 1'b1, 1'b1, 3'd4, 36'h0, 1'b0},
    '{32'h0003_0ABC, 2'd0, 1'b1, 1'b1, 1'b0, 3'd0, 36'h000777ABC, 1'b1},
    '{32'h0004_0000, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 36'h0, 1'b0},
    '{32'h0009_9000, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 36'h0, 1'b0},
    '{32'h0002_0010, 2'd1, 1'b1, 1'b1, 1'b1, 3'd1, 36'h0, 1'b0},
    '{32'h0009_9000, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 36'h0, 1'b0}
  };

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic do_refill(logic [31:0] va, logic [31:0] desc);
    @(negedge clk);
    rf_valid = 1'b1; rf_vaddr = va; rf_desc = desc;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic do_ctl(logic [1:0] cmd, logic [31:0] data);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_cmd = cmd; ctl_wdata = data;
    @(negedge clk);
    ctl_valid = 1'b0;
  endtask

  // result sampled one edge after the request
  task automatic do_lookup(logic [31:0] va, logic [1:0] acc, logic user);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc; lk_user = user;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  function automatic string tag_of(vec_t v);
    if (!v.hit) return "R4";
    case (v.err)
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R2 R3";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, translation off (R12)
    check("R12", "done after reset", 64'(lk_done), 64'd0);
    check("R10", "ctx after reset", 64'(ctx_ptr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // bypass while off (R12)
    do_lookup(32'hDEAD_B123, 2'd1, 1'b1);
    check("R12", "bypass hit", 64'(lk_hit), 64'd1);
    check("R12", "bypass fault", 64'(lk_fault), 64'd0);
    check("R12", "bypass paddr", 64'(lk_paddr), 64'h0DEADB123);
    check("R12", "bypass cacheable", 64'(lk_cacheable), 64'd1);

    // R1 descriptor layout; slot 3 has kind 00 and stays invalid
    do_refill(32'h0001_0000, 32'h7500_0AB0);
    do_refill(32'h0002_0000, 32'h4A12_3456);
    do_refill(32'h0003_0000, 32'h7400_0777);
    do_refill(32'h0004_0000, 32'h3F00_0999);
    do_ctl(2'd1, 32'd1);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = tag_of(VECS[i]);
      do_lookup(VECS[i].va, VECS[i].acc, VECS[i].user);
      check(t, $sformatf("v%0d done", i), 64'(lk_done), 64'd1);
      check(t, $sformatf("v%0d hit", i), 64'(lk_hit), 64'(VECS[i].hit));
      check(t, $sformatf("v%0d miss", i), 64'(lk_miss), 64'(!VECS[i].hit));
      check(t, $sformatf("v%0d fault", i), 64'(lk_fault), 64'(VECS[i].fault));
      check(t, $sformatf("v%0d code", i), 64'(lk_err), 64'(VECS[i].err));
      if (VECS[i].hit && !VECS[i].fault) begin
        check("R2", $sformatf("v%0d paddr", i), 64'(lk_paddr), 64'(VECS[i].pa));
        check("R3", $sformatf("v%0d cacheable", i), 64'(lk_cacheable), 64'(VECS[i].c));
      end
    end

    // R9: last fault was v10; later misses did not disturb it (R4)
    do_ctl(2'd3, 32'd0);
    check("R9", "bad address", 64'(ctl_rdata), 64'h0002_0010);
    do_ctl(2'd3, 32'd1);
    check("R9", "fault code", 64'(ctl_rdata), 64'd1);

    // R11 line invalidate
    do_ctl(2'd2, 32'h0001_0ABC);
    do_lookup(32'h0001_0123, 2'd0, 1'b0);
    check("R11", "invalidated line", 64'(lk_miss), 64'd1);
    do_lookup(32'h0003_0004, 2'd0, 1'b0);
    check("R11", "other line kept", 64'(lk_paddr), 64'h000777004);

    // R10 context switch
    do_ctl(2'd0, 32'h0000_1234);
    check("R10", "ctx pointer", 64'(ctx_ptr), 64'h1234);
    do_lookup(32'h0003_0004, 2'd0, 1'b0);
    check("R10", "non-global flushed", 64'(lk_miss), 64'd1);
    do_lookup(32'h0002_0008, 2'd2, 1'b0);
    check("R10", "global kept", 64'(lk_hit), 64'd1);
    check("R10", "global paddr", 64'(lk_paddr), 64'h123456008);

    // R13 round robin: 8 refills go to slots 4..7,0..3, evicting slot 1
    for (int i = 0; i < 8; i++) do_refill(32'h0020_0000 + (i << 12), 32'h4400_0500 + i);
    do_lookup(32'h0002_0008, 2'd2, 1'b0);
    check("R13", "global evicted", 64'(lk_miss), 64'd1);
    for (int i = 0; i < 8; i++) begin
      do_lookup(32'h0020_0010 + (i << 12), 2'd0, 1'b0);
      check("R13", $sformatf("new slot %0d", i), 64'(lk_paddr), 64'h000500010 + (64'(i) << 12));
    end

    // R12 disable again: no faults, identity mapping
    do_ctl(2'd1, 32'd0);
    do_lookup(32'h0002_0010, 2'd1, 1'b1);
    check("R12", "off no fault", 64'(lk_fault), 64'd0);
    check("R12", "off paddr", 64'(lk_paddr), 64'h000020010);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule